// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the program-flow slice of a small 8-bit processor core. It owns the 10-bit program counter, a circular call/return address stack, a one-level shadow of the zero and carry flags, and the interrupt-enable flag. Every instruction takes two clocks: a fetch phase that presents the address, then an execute phase. At the end of the execute phase a decoded operation code from the instruction decoder updates the program counter.

At each fetch phase the block samples the interrupt request, but only while interrupts are enabled. When it accepts a request, the instruction just fetched is preempted and its own address is pushed as the return point. The block copies the ALU's zero and carry flags into the shadow, clears the enable flag, loads the all-ones vector address and pulses the acknowledge output. A return-from-interrupt pops the stack, presents the shadowed flags to the ALU with a restore strobe, and sets or clears the enable flag as its argument bit says.

The controller has four states. FETCH goes to EXEC when no interrupt is accepted and to VEC_CALL when one is. EXEC always goes back to FETCH. VEC_CALL always goes to VEC_LOAD, and VEC_LOAD always goes to FETCH. The first FETCH after VEC_LOAD presents the vector address.

Top module: `irq_flow_seq`

## Requirements
- R1: While reset is low and just after it: pc_o is 0x000, ie_o is 0, irq_ack_o is 0, zero_restore_o and carry_restore_o are 0, fetch_o is 1 and the stack is empty.
- R2: Each instruction is a fetch cycle (fetch_o=1) followed by an execute cycle (fetch_o=0). The operation code is applied at the end of the execute cycle. Op code 0 (NEXT) increments pc modulo 1024, so 0x3FF goes to 0x000.
- R3: Op codes: 0 NEXT, 1 JUMP (pc := target_i), 2 CALL, 3 RET, 4 RETI, 5 SETIE. Codes 6 and 7 behave as NEXT.
- R4: CALL pushes pc+1 and loads target_i. RET pops the stack into pc, leaves ie_o unchanged and does not raise flag_restore_o.
- R5: When irq_i is 1 in a fetch cycle and ie_o is 1, the fetched instruction is preempted. Its op code is ignored and its own address is pushed, so a later RETI resumes at that address.
- R6: On interrupt entry, alu_zero_i and alu_carry_i are copied to zero_restore_o and carry_restore_o, ie_o is cleared and pc becomes 0x3FF (all ones).
- R7: irq_ack_o is high for exactly the two cycles after the accepting fetch cycle. It is low again in the fetch cycle that presents 0x3FF.
- R8: irq_i while ie_o is 0 is ignored and not remembered. Enabling later with irq_i low does not cause an entry.
- R9: RETI pops the stack into pc and sets ie_o to op_arg_i. During its execute cycle flag_restore_o is 1 and the shadow values are driven.
- R10: SETIE sets ie_o to op_arg_i and increments pc.
- R11: The stack holds 31 entries in a ring. A push when full overwrites the oldest entry, and a pop when empty wraps to the last slot.
- R12: The shadow flags change only on interrupt entry or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Decoded operation code, used in the execute cycle |
| op_arg_i | input | 1 | Enable bit for RETI and SETIE |
| target_i | input | 10 | Branch or call target address |
| irq_i | input | 1 | Interrupt request |
| alu_zero_i | input | 1 | Current zero flag from the ALU |
| alu_carry_i | input | 1 | Current carry flag from the ALU |
| pc_o | output | 10 | Instruction address |
| fetch_o | output | 1 | High in the fetch cycle of an instruction |
| irq_ack_o | output | 1 | Interrupt acknowledge |
| ie_o | output | 1 | Interrupt-enable flag |
| flag_restore_o | output | 1 | Strobe telling the ALU to load the shadow flags |
| zero_restore_o | output | 1 | Shadowed zero flag |
| carry_restore_o | output | 1 | Shadowed carry flag |

## Verification
Interrupt acceptance and instruction execution compete for the same fetch boundary. The bench presents a CALL on op_i in the very fetch cycle in which irq_i is raised with interrupts enabled. It judges the outcome by checking that the acknowledge pulse appears, that the vector is reached, and that RETI then lands back on the preempted CALL's own address with the CALL never taken. A second collision drives irq_i high while the handler's jump executes with the enable flag clear. The bench checks that no second entry occurs and that the shadow flags keep their entry values.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

    typedef enum logic [2:0] {
        OP_NEXT  = 3'd0,
        OP_JUMP  = 3'd1,
        OP_CALL  = 3'd2,
        OP_RET   = 3'd3,
        OP_RETI  = 3'd4,
        OP_SETIE = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_FETCH    = 2'd0,
        ST_EXEC     = 2'd1,
        ST_VEC_CALL = 2'd2,
        ST_VEC_LOAD = 2'd3
    } state_e;

endpackage

// File: rtl/irqseq_stack.sv
module irqseq_stack #(
    parameter int DEPTH = 31,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_data_i,
    output logic [AW-1:0] top_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] sp_q;
    logic [PW-1:0] sp_up, sp_down;

    // ring arithmetic on the pointer
    always_comb begin
        sp_up   = (sp_q == LAST) ? '0 : sp_q + 1'b1;
        sp_down = (sp_q == '0) ? LAST : sp_q - 1'b1;
    end

    assign top_o = mem[sp_down];

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem[sp_q] <= push_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (push_i && !pop_i) begin
            sp_q <= sp_up;
        end else if (pop_i && !push_i) begin
            sp_q <= sp_down;
        end
    end

    assert_sp_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= LAST);

    assert_pop_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && sp_q == '0) |=> (sp_q == LAST));

    assert_single_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

endmodule

// File: rtl/irqseq_flags.sv
module irqseq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic capture_i,
    input  logic zero_i,
    input  logic carry_i,
    output logic zero_o,
    output logic carry_o
);
    logic zero_q, carry_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_q  <= 1'b0;
            carry_q <= 1'b0;
        end else if (capture_i) begin
            zero_q  <= zero_i;
            carry_q <= carry_i;
        end
    end

    assign zero_o  = zero_q;
    assign carry_o = carry_q;

    assert_shadow_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> ($stable(zero_q) && $stable(carry_q)));

endmodule

// File: rtl/irqseq_ctrl.sv
module irqseq_ctrl
    import irqseq_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op_i,
    input  logic          op_arg_i,
    input  logic [AW-1:0] target_i,
    input  logic          irq_i,
    input  logic [AW-1:0] stack_top_i,
    output logic [AW-1:0] pc_o,
    output logic          fetch_o,
    output logic          ack_o,
    output logic          ie_o,
    output logic          push_o,
    output logic          pop_o,
    output logic [AW-1:0] push_data_o,
    output logic          capture_o,
    output logic          restore_o
);
    localparam logic [AW-1:0] VECTOR = '1;

    state_e        state_q, state_d;
    logic [AW-1:0] pc_q, pc_inc;
    logic          ie_q;
    logic          take_irq;

    assign pc_inc   = pc_q + 1'b1;
    assign take_irq = irq_i & ie_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:    state_d = take_irq ? ST_VEC_CALL : ST_EXEC;
            ST_EXEC:     state_d = ST_FETCH;
            ST_VEC_CALL: state_d = ST_VEC_LOAD;
            ST_VEC_LOAD: state_d = ST_FETCH;
        endcase
    end

    // per-state outputs
    always_comb begin
        fetch_o     = 1'b0;
        ack_o       = 1'b0;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        push_data_o = pc_inc;
        capture_o   = 1'b0;
        restore_o   = 1'b0;
        unique case (state_q)
            ST_FETCH: fetch_o = 1'b1;
            ST_EXEC: begin
                case (op_i)
                    OP_CALL: push_o = 1'b1;
                    OP_RET:  pop_o  = 1'b1;
                    OP_RETI: begin
                        pop_o     = 1'b1;
                        restore_o = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_VEC_CALL: begin
                ack_o       = 1'b1;
                push_o      = 1'b1;
                push_data_o = pc_q;
                capture_o   = 1'b1;
            end
            ST_VEC_LOAD: ack_o = 1'b1;
        endcase
    end

    // program counter and enable flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            ie_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_EXEC: begin
                    case (op_i)
                        OP_JUMP, OP_CALL: pc_q <= target_i;
                        OP_RET:           pc_q <= stack_top_i;
                        OP_RETI: begin
                            pc_q <= stack_top_i;
                            ie_q <= op_arg_i;
                        end
                        OP_SETIE: begin
                            pc_q <= pc_inc;
                            ie_q <= op_arg_i;
                        end
                        default:          pc_q <= pc_inc;
                    endcase
                end
                ST_VEC_CALL: begin
                    pc_q <= VECTOR;
                    ie_q <= 1'b0;
                end
                ST_FETCH, ST_VEC_LOAD: ;
            endcase
        end
    end

    assign pc_o = pc_q;
    assign ie_o = ie_q;

    assert_vector_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VEC_CALL) |=> (pc_q == VECTOR && !ie_q));

    assert_preempt_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && take_irq) |=> (push_o && push_data_o == $past(pc_q)));

    assert_disabled_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && !ie_q) |=> (state_q == ST_EXEC));

    assert_ack_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |=> (ack_o ##1 !ack_o));

    assert_ret_keeps_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && op_i == OP_RET) |=> $stable(ie_q));

    assert_two_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC) |=> (state_q == ST_FETCH));

endmodule

// File: rtl/irq_flow_seq.sv
module irq_flow_seq
    import irqseq_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int STACK_DEPTH = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic              op_arg_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              irq_i,
    input  logic              alu_zero_i,
    input  logic              alu_carry_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              fetch_o,
    output logic              irq_ack_o,
    output logic              ie_o,
    output logic              flag_restore_o,
    output logic              zero_restore_o,
    output logic              carry_restore_o
);
    logic              push, pop, capture;
    logic [ADDR_W-1:0] push_data, stack_top;
    op_e               op_dec;

    assign op_dec = op_e'(op_i);

    irqseq_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op_dec),
        .op_arg_i    (op_arg_i),
        .target_i    (target_i),
        .irq_i       (irq_i),
        .stack_top_i (stack_top),
        .pc_o        (pc_o),
        .fetch_o     (fetch_o),
        .ack_o       (irq_ack_o),
        .ie_o        (ie_o),
        .push_o      (push),
        .pop_o       (pop),
        .push_data_o (push_data),
        .capture_o   (capture),
        .restore_o   (flag_restore_o)
    );

    irqseq_stack #(.DEPTH(STACK_DEPTH), .AW(ADDR_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (push_data),
        .top_o       (stack_top)
    );

    irqseq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .zero_i    (alu_zero_i),
        .carry_i   (alu_carry_i),
        .zero_o    (zero_restore_o),
        .carry_o   (carry_restore_o)
    );

    assert_restore_on_exec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_restore_o |-> (!fetch_o && !irq_ack_o));

endmodule

// File: tb/irq_flow_seq_test.sv
`timescale 1ns/1ps
module irq_flow_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic       op_arg_i = 1'b0;
    logic [9:0] target_i = '0;
    logic       irq_i = 1'b0;
    logic       alu_zero_i = 1'b0;
    logic       alu_carry_i = 1'b0;
    logic [9:0] pc_o;
    logic       fetch_o, irq_ack_o, ie_o, flag_restore_o, zero_restore_o, carry_restore_o;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    irq_flow_seq uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .op_i            (op_i),
        .op_arg_i        (op_arg_i),
        .target_i        (target_i),
        .irq_i           (irq_i),
        .alu_zero_i      (alu_zero_i),
        .alu_carry_i     (alu_carry_i),
        .pc_o            (pc_o),
        .fetch_o         (fetch_o),
        .irq_ack_o       (irq_ack_o),
        .ie_o            (ie_o),
        .flag_restore_o  (flag_restore_o),
        .zero_restore_o  (zero_restore_o),
        .carry_restore_o (carry_restore_o)
    );

    // {op[2:0], arg, target[9:0], expected pc[9:0]}  (R2, R3, R4, R10)
    localparam logic [23:0] VEC [12] = '{
        {3'd0, 1'b0, 10'h000, 10'h001},
        {3'd0, 1'b0, 10'h000, 10'h002},
        {3'd1, 1'b0, 10'h100, 10'h100},
        {3'd2, 1'b0, 10'h200, 10'h200},
        {3'd0, 1'b0, 10'h000, 10'h201},
        {3'd2, 1'b0, 10'h300, 10'h300},
        {3'd3, 1'b0, 10'h000, 10'h202},
        {3'd3, 1'b0, 10'h000, 10'h101},
        {3'd5, 1'b0, 10'h000, 10'h102},
        {3'd1, 1'b0, 10'h3FE, 10'h3FE},
        {3'd6, 1'b0, 10'h000, 10'h3FF},
        {3'd0, 1'b0, 10'h000, 10'h000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // entered and left at a negedge inside a fetch cycle
    task automatic instr(input logic [2:0] op, input logic arg, input logic [9:0] tgt,
                         input logic irq, output logic rs, output logic rz,
                         output logic rc, output logic ak);
        op_i = op; op_arg_i = arg; target_i = tgt; irq_i = irq;
        @(posedge clk); @(negedge clk);
        rs = flag_restore_o; rz = zero_restore_o; rc = carry_restore_o; ak = irq_ack_o;
        @(posedge clk); @(negedge clk);
        irq_i = 1'b0; op_i = 3'd0;
    endtask

    task automatic enter_irq(input logic [2:0] op, input logic [9:0] pc_before,
                             input logic z, input logic c);
        op_i = op; target_i = 10'h155; irq_i = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 ack in first vector cycle", irq_ack_o, 1);
        chk("R5 fetch halted", fetch_o, 0);
        chk("R5 pc held", pc_o, pc_before);
        irq_i = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7 ack in second vector cycle", irq_ack_o, 1);
        chk("R6 vector pc", pc_o, 10'h3FF);
        chk("R6 ie cleared", ie_o, 0);
        chk("R6 zero shadowed", zero_restore_o, z);
        chk("R6 carry shadowed", carry_restore_o, c);
        @(posedge clk); @(negedge clk);
        chk("R7 ack low at vector fetch", irq_ack_o, 0);
        chk("R7 vector fetched", {fetch_o, pc_o}, {1'b1, 10'h3FF});
        op_i = 3'd0;
    endtask

    initial begin
        logic rs, rz, rc, ak;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset pc", pc_o, 0);
        chk("R1 reset ie", ie_o, 0);
        chk("R1 reset ack", irq_ack_o, 0);
        chk("R1 reset shadow", {zero_restore_o, carry_restore_o}, 0);
        chk("R1 reset fetch phase", fetch_o, 1);
        rst_n = 1'b1;

        // table walk: R2 R3 R4 R10
        for (int i = 0; i < 12; i++) begin
            instr(VEC[i][23:21], VEC[i][20], VEC[i][19:10], 1'b0, rs, rz, rc, ak);
            chk($sformatf("R3 table step %0d pc", i), pc_o, VEC[i][9:0]);
        end
        chk("R2 fetch phase after instr", fetch_o, 1);

        // R8: request while disabled is ignored and not remembered
        instr(3'd0, 1'b0, 10'h0, 1'b1, rs, rz, rc, ak);
        chk("R8 no ack while disabled", ak, 0);
        chk("R8 pc advanced", pc_o, 10'h001);
        instr(3'd5, 1'b1, 10'h0, 1'b0, rs, rz, rc, ak);
        chk("R10 ie set", ie_o, 1);
        chk("R10 pc advanced", pc_o, 10'h002);
        instr(3'd0, 1'b0, 10'h0, 1'b0, rs, rz, rc, ak);
        chk("R8 not latched", pc_o, 10'h003);

        // R5 R6 R7: entry collides with a CALL at the same fetch
        alu_zero_i = 1'b1; alu_carry_i = 1'b0;
        enter_irq(3'd2, 10'h003, 1'b1, 1'b0);
        alu_zero_i = 1'b0; alu_carry_i = 1'b1;
        instr(3'd1, 1'b0, 10'h080, 1'b1, rs, rz, rc, ak);
        chk("R8 no re-entry in handler", ak, 0);
        chk("R8 handler jump", pc_o, 10'h080);
        chk("R12 shadow kept", {zero_restore_o, carry_restore_o}, 2'b10);
        instr(3'd4, 1'b1, 10'h0, 1'b0, rs, rz, rc, ak);
        chk("R9 restore strobe", rs, 1);
        chk("R9 restored flags", {rz, rc}, 2'b10);
        chk("R5 resumes at preempted address", pc_o, 10'h003);
        chk("R9 ie re-enabled", ie_o, 1);

        // second entry, return with interrupts left disabled
        enter_irq(3'd0, 10'h003, 1'b0, 1'b1);
        instr(3'd4, 1'b0, 10'h0, 1'b0, rs, rz, rc, ak);
        chk("R9 restored flags 2", {rs, rz, rc}, 3'b101);
        chk("R9 pc after return", pc_o, 10'h003);
        chk("R9 ie stays disabled", ie_o, 0);

        // R4: plain return leaves ie alone, no restore strobe
        instr(3'd5, 1'b1, 10'h0, 1'b0, rs, rz, rc, ak);
        instr(3'd2, 1'b0, 10'h040, 1'b0, rs, rz, rc, ak);
        chk("R4 call target", pc_o, 10'h040);
        instr(3'd3, 1'b0, 10'h0, 1'b0, rs, rz, rc, ak);
        chk("R4 ret no restore", rs, 0);
        chk("R4 ret pc", pc_o, 10'h005);
        chk("R4 ret keeps ie", ie_o, 1);
        instr(3'd5, 1'b0, 10'h0, 1'b0, rs, rz, rc, ak);
        chk("R10 ie cleared", ie_o, 0);

        // R11: 32 pushes into 31 slots, then 32 pops
        for (int k = 0; k < 32; k++) begin
            instr(3'd1, 1'b0, 10'(k * 8), 1'b0, rs, rz, rc, ak);
            instr(3'd2, 1'b0, 10'h300, 1'b0, rs, rz, rc, ak);
        end
        for (int j = 0; j < 31; j++) begin
            instr(3'd3, 1'b0, 10'h0, 1'b0, rs, rz, rc, ak);
            chk($sformatf("R11 pop %0d", j), pc_o, 10'((31 - j) * 8 + 1));
        end
        instr(3'd3, 1'b0, 10'h0, 1'b0, rs, rz, rc, ak);
        chk("R11 pop from empty wraps", pc_o, 10'd249);

        // R1: reset in mid-run
        instr(3'd5, 1'b1, 10'h0, 1'b0, rs, rz, rc, ak);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 mid reset pc", pc_o, 0);
        chk("R1 mid reset ie", ie_o, 0);
        chk("R1 mid reset shadow", {zero_restore_o, carry_restore_o}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule